// File: doc/BRIEF.md
# I2C Page-Write Target Front End

This block is the serial-bus target side of a 256-location register and memory space. It oversamples the bus clock and data lines with the system clock. It detects START, repeated START and STOP, and decides whether the address byte is meant for it. A select pin chooses the address source. With the pin low, a fixed address is used. With the pin high, the upper seven bits of a programmable address register are used.

After a write-direction address, the first byte loads an internal address pointer. Each following byte goes out on a one-cycle memory write strobe. Write bursts stay inside an 8-byte row: only the low three pointer bits advance.

A read-direction address streams bytes from the pointer. The pointer advances by one after each byte, until the master answers with NACK. When a write that carried data ends with STOP, the block issues a commit request. For a programmable number of system clocks after that, it refuses to acknowledge its own address.

Top module: `i2c_pg_target`

## Requirements
- R1: With `addr_sel_i` low, the block acknowledges only the 7-bit address 0x51, sent on the bus as byte A2h (write) or A3h (read). Any other address byte gets no ACK.
- R2: With `addr_sel_i` high, the block acknowledges an address byte whose upper seven bits equal `addr_reg_i[7:1]`. `addr_reg_i[0]` has no effect on the match.
- R3: In a write transfer, the first byte after the address byte loads the pointer. Each later byte produces one `mem_we_o` pulse, with `mem_wr_addr_o` set to the pointer and `mem_wr_data_o` set to the byte.
- R4: After each written byte, pointer bits [2:0] increment modulo 8 and bits [7:3] stay unchanged, so a burst that runs past a row end wraps to the start of the same row.
- R5: A read with no address byte before it starts at the current pointer. A pointer write followed by a repeated START and a read starts the read at the written pointer.
- R6: During a read, the pointer increments by one modulo 256 after every byte, across row boundaries. A master ACK (SDA low on the ninth clock) fetches the next byte. A master NACK makes the block release SDA and drive nothing until the next START.
- R7: A STOP that ends a transfer in which at least one data byte was written gives exactly one `commit_o` pulse. A transfer that wrote only the pointer gives none. For `BUSY_CYCLES` system clocks after the pulse, the block does not acknowledge its own address.
- R8: After an address byte that does not match, the block gives no ACK, issues no memory write and no commit, and ignores all traffic until the next START.
- R9: Bytes travel MSB first. The block acknowledges by pulling SDA low on the ninth clock. `sda_oe_o` changes only while SCL is low.
- R10: While `rst_ni` is low, `sda_oe_o`, `mem_we_o` and `commit_o` are 0 and `mem_rd_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_sel_i | input | 1 | 0 selects the fixed address, 1 selects the programmable one |
| addr_reg_i | input | 8 | Programmable address register; bits [7:1] are used |
| mem_we_o | output | 1 | One-cycle write strobe toward the memory |
| mem_wr_addr_o | output | 8 | Write location |
| mem_wr_data_o | output | 8 | Write data |
| mem_re_o | output | 1 | One-cycle pulse when a read byte is fetched |
| mem_rd_addr_o | output | 8 | Read location (the current pointer) |
| mem_rd_data_i | input | 8 | Data at `mem_rd_addr_o`, combinational |
| commit_o | output | 1 | Request to commit written data, one pulse after STOP |

## Verification
The bench targets these corner cases:

- **Row end during a write burst.** A pointer that carried into bit 3 would put the fourth and fifth bytes in the next row instead of at 38h and 39h.
- **Read across the same row boundary.** Here the pointer must carry. A read counter that reused the page wrap would return the byte from 38h instead of 40h.
- **Address acknowledge during the commit window.** A missing busy guard would ACK straight after STOP.
- **Pointer-only write.** A commit on it would signal a nonvolatile write that has no data.
- **Address select, including the ignored low bit of the programmable register.** A mismatch that still counted later bytes as data would produce stray write strobes.
- **After a master NACK.** An extra clock must read back as released.

// File: rtl/i2c_pg_pkg.sv
package i2c_pg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } state_e;

  // pick the 7-bit target address source
  function automatic logic [6:0] pick_target(input logic sel, input logic [7:0] fixed_byte,
                                             input logic [7:0] prog_byte);
    return sel ? prog_byte[7:1] : fixed_byte[7:1];
  endfunction

endpackage

// File: rtl/i2c_pg_sync.sv
module i2c_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff[k] <= 1'b1;
          sda_ff[k] <= 1'b1;
        end else begin
          scl_ff[k] <= scl_ff[k-1];
          sda_ff[k] <= sda_ff[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_ff[STAGES-1];
      sda_d <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;

endmodule

// File: rtl/i2c_pg_ptr.sv
module i2c_pg_ptr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_page_i,
  input  logic          step_lin_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q, page_next, lin_next;

  assign lin_next = ptr_q + 1'b1;

  if (PAGE_BITS >= AW) begin : g_full_page
    assign page_next = lin_next;
  end else begin : g_split_page
    logic [PAGE_BITS-1:0] page_lo;
    assign page_lo   = ptr_q[PAGE_BITS-1:0] + 1'b1;
    assign page_next = {ptr_q[AW-1:PAGE_BITS], page_lo};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (load_i)      ptr_q <= load_val_i;
    else if (step_page_i) ptr_q <= page_next;
    else if (step_lin_i)  ptr_q <= lin_next;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_pg_busy.sv
module i2c_pg_busy #(
  parameter int CYCLES = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/i2c_pg_target.sv
module i2c_pg_target
  import i2c_pg_pkg::*;
#(
  parameter int         DW          = 8,
  parameter int         PAGE_BITS   = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 600,
  parameter logic [7:0] FIXED_ADDR  = 8'hA2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          addr_sel_i,
  input  logic [DW-1:0] addr_reg_i,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wr_addr_o,
  output logic [DW-1:0] mem_wr_data_o,
  output logic          mem_re_o,
  output logic [DW-1:0] mem_rd_addr_o,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          commit_o
);

  localparam int AW  = DW;
  localparam int BCW = $clog2(DW + 1);

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic busy;
  logic [AW-1:0] ptr_q;

  state_e         st_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [DW-1:0]  sh_q;
  logic           rw_q, wrote_q, sda_oe_q, mack_q;
  logic           we_q, re_q, commit_q;
  logic [AW-1:0]  wr_addr_q;
  logic [DW-1:0]  wr_data_q;

  logic       byte_done, dev_hit;
  logic       ptr_load, ptr_step_page, ptr_step_lin;
  logic [6:0] target;
  logic       unused_lsb;

  i2c_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .start_o (start_det),
    .stop_o  (stop_det),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  i2c_pg_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ptr_load),
    .load_val_i  (sh_q),
    .step_page_i (ptr_step_page),
    .step_lin_i  (ptr_step_lin),
    .ptr_o       (ptr_q)
  );

  i2c_pg_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_q),
    .busy_o  (busy)
  );

  assign unused_lsb = addr_reg_i[0];
  assign target     = pick_target(addr_sel_i, FIXED_ADDR, addr_reg_i);
  assign byte_done  = (bit_cnt_q == BCW'(DW));
  assign dev_hit    = (sh_q[DW-1:1] == target) && !busy;

  // pointer controls; START/STOP occur only with SCL high, so never with a fall
  always_comb begin
    ptr_load      = 1'b0;
    ptr_step_page = 1'b0;
    ptr_step_lin  = 1'b0;
    if (scl_fall && byte_done) begin
      unique case (st_q)
        ST_MADDR: ptr_load      = 1'b1;
        ST_WDATA: ptr_step_page = 1'b1;
        ST_RDATA: ptr_step_lin  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      wrote_q   <= 1'b0;
      sda_oe_q  <= 1'b0;
      mack_q    <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      commit_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      commit_q <= 1'b0;
      if (start_det) begin
        st_q      <= ST_DEV;
        bit_cnt_q <= '0;
        sda_oe_q  <= 1'b0;
      end else if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
        commit_q <= wrote_q;
        wrote_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_MADDR, ST_WDATA: begin
            if (scl_rise && !byte_done) begin
              sh_q      <= {sh_q[DW-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && byte_done) begin
              sda_oe_q <= 1'b1;
              if (st_q == ST_DEV) begin
                if (dev_hit) begin
                  rw_q <= sh_q[0];
                  st_q <= ST_DEV_ACK;
                end else begin
                  sda_oe_q <= 1'b0;
                  st_q     <= ST_IGNORE;
                end
              end else if (st_q == ST_MADDR) begin
                st_q <= ST_MADDR_ACK;
              end else begin
                we_q      <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= sh_q;
                wrote_q   <= 1'b1;
                st_q      <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                sh_q     <= mem_rd_data_i;
                sda_oe_q <= ~mem_rd_data_i[DW-1];
                re_q     <= 1'b1;
                st_q     <= ST_RDATA;
              end else begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_MADDR;
              end
            end
          end
          ST_MADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe_q  <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise && !byte_done) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                sda_oe_q <= 1'b0;
                st_q     <= ST_RDATA_ACK;
              end else begin
                sda_oe_q <= ~sh_q[DW-2];
                sh_q     <= {sh_q[DW-2:0], 1'b0};
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q      <= mem_rd_data_i;
                sda_oe_q  <= ~mem_rd_data_i[DW-1];
                re_q      <= 1'b1;
                bit_cnt_q <= '0;
                st_q      <= ST_RDATA;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o      = sda_oe_q;
  assign mem_we_o      = we_q;
  assign mem_wr_addr_o = wr_addr_q;
  assign mem_wr_data_o = wr_data_q;
  assign mem_re_o      = re_q;
  assign mem_rd_addr_o = ptr_q;
  assign commit_o      = commit_q;

endmodule

// File: rtl/i2c_pg_target_chk.sv
module i2c_pg_target_chk
  import i2c_pg_pkg::*;
#(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          sda_oe_i,
  input logic          mem_we_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [AW-1:0] ptr_i,
  input logic          commit_i,
  input logic          stop_i,
  input logic          busy_i,
  input state_e        st_i
);

  a_r9_sda_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));

  a_r4_page_wrap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (ptr_i[AW-1:PAGE_BITS] == wr_addr_i[AW-1:PAGE_BITS]) &&
                 (ptr_i[PAGE_BITS-1:0] == PAGE_BITS'(wr_addr_i[PAGE_BITS-1:0] + 1'b1)));

  a_r7_commit_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(stop_i));

  a_r7_no_ack_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_DEV_ACK) |-> !busy_i);

  a_r7_no_write_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !busy_i);

endmodule

bind i2c_pg_target i2c_pg_target_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s_i   (scl_s),
  .sda_oe_i  (sda_oe_o),
  .mem_we_i  (mem_we_o),
  .wr_addr_i (mem_wr_addr_o),
  .ptr_i     (ptr_q),
  .commit_i  (commit_o),
  .stop_i    (stop_det),
  .busy_i    (busy),
  .st_i      (st_q)
);

// File: tb/i2c_pg_target_bench.sv
module i2c_pg_target_bench;

  localparam int Q    = 10;
  localparam int BUSY = 600;

  // {addr_sel, addr_reg, address byte, expect ack}
  localparam logic [17:0] VECS [8] = '{
    {1'b0, 8'hA0, 8'hA2, 1'b1},
    {1'b0, 8'hA0, 8'hA0, 1'b0},
    {1'b1, 8'hA0, 8'hA0, 1'b1},
    {1'b1, 8'hA0, 8'hA2, 1'b0},
    {1'b1, 8'h6D, 8'h6C, 1'b1},
    {1'b1, 8'h6D, 8'h6E, 1'b0},
    {1'b1, 8'h6C, 8'h6C, 1'b1},
    {1'b0, 8'h6C, 8'h6C, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] addr_reg = 8'hA0;
  logic sda_oe, we, re, commit;
  logic [7:0] wa, wd, ra, rd;
  logic sda_line;

  logic [7:0] mem [256];
  logic [7:0] log_a [32];
  logic [7:0] log_d [32];
  int wcnt = 0;
  int ccnt = 0;
  int viol = 0;
  int nchk = 0;
  int nfail = 0;
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rd = mem[ra];

  i2c_pg_target #(.BUSY_CYCLES(BUSY)) u_i2c_pg_target (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .addr_sel_i    (addr_sel),
    .addr_reg_i    (addr_reg),
    .mem_we_o      (we),
    .mem_wr_addr_o (wa),
    .mem_wr_data_o (wd),
    .mem_re_o      (re),
    .mem_rd_addr_o (ra),
    .mem_rd_data_i (rd),
    .commit_o      (commit)
  );

  always @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
      if (wcnt < 32) begin
        log_a[wcnt] <= wa;
        log_d[wcnt] <= wd;
      end
      wcnt <= wcnt + 1;
    end
    if (commit) ccnt <= ccnt + 1;
    if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) viol <= viol + 1;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  task automatic check(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nak);
    ack = ~nak;
  endtask

  task automatic read_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic ack;
    logic b;
    logic [7:0] d;
    int w0, c0;
    for (int i = 0; i < 256; i++) mem[i] = i[7:0] ^ 8'h5A;

    // R10 reset state
    repeat (5) @(negedge clk);
    check("R10 sda_oe in reset", sda_oe, 0);
    check("R10 mem_we in reset", we, 0);
    check("R10 commit in reset", commit, 0);
    check("R10 pointer in reset", ra, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2 address match table
    for (int v = 0; v < 8; v++) begin
      addr_sel = VECS[v][17];
      addr_reg = VECS[v][16:9];
      wq();
      bus_start();
      write_byte(VECS[v][8:1], ack);
      bus_stop();
      check($sformatf("R1/R2 vector %0d ack", v), ack, VECS[v][0]);
    end
    check("R2 no writes from address-only transfers", wcnt, 0);
    check("R7 no commit from address-only transfers", ccnt, 0);

    // R3 R4 page write wrapping within row 38h-3Fh
    addr_sel = 1'b0;
    wq();
    bus_start();
    write_byte(8'hA2, ack); check("R3 address ack", ack, 1);
    write_byte(8'h3D, ack); check("R3 pointer ack", ack, 1);
    for (int i = 0; i < 5; i++) begin
      write_byte(8'h11 + i[7:0], ack);
      check("R3 data ack", ack, 1);
    end
    bus_stop();
    check("R3 write strobe count", wcnt, 5);
    for (int i = 0; i < 5; i++) begin
      check($sformatf("R4 write %0d address", i), log_a[i], {5'b00111, 3'(5 + i)});
      check($sformatf("R3 write %0d data", i), log_d[i], 8'h11 + i);
    end
    check("R7 one commit after data write", ccnt, 1);

    // R7 busy window NACKs own address
    bus_start();
    write_byte(8'hA2, ack);
    check("R7 address refused while busy", ack, 0);
    bus_stop();
    repeat (BUSY + 100) @(negedge clk);

    // R5 R6 pointer set, repeated START, read across row boundary
    bus_start();
    write_byte(8'hA2, ack); check("R5 address ack after busy", ack, 1);
    write_byte(8'h3E, ack); check("R5 pointer ack", ack, 1);
    bus_rstart();
    write_byte(8'hA3, ack); check("R5 read address ack", ack, 1);
    read_byte(d, 1'b1); check("R5 R9 read byte 3Eh", d, 8'h12);
    read_byte(d, 1'b1); check("R6 read byte 3Fh", d, 8'h13);
    read_byte(d, 1'b0); check("R6 read byte 40h crosses row", d, 8'h40 ^ 8'h5A);
    bus_stop();
    check("R7 pointer-only write gives no commit", ccnt, 1);

    // R5 current-address read, R6 release after NACK
    bus_start();
    write_byte(8'hA3, ack); check("R5 current read ack", ack, 1);
    read_byte(d, 1'b0); check("R5 current address byte 41h", d, 8'h41 ^ 8'h5A);
    recv_bit(b); check("R6 SDA released after NACK", b, 1);
    bus_stop();

    // R8 mismatch ignores following bytes
    w0 = wcnt; c0 = ccnt;
    bus_start();
    write_byte(8'hA4, ack); check("R8 mismatch nack", ack, 0);
    write_byte(8'h00, ack); check("R8 ignored byte not acked", ack, 0);
    write_byte(8'h99, ack); check("R8 ignored data not acked", ack, 0);
    bus_stop();
    check("R8 no write after mismatch", wcnt, w0);
    check("R8 no commit after mismatch", ccnt, c0);
    bus_start();
    write_byte(8'hA2, ack); check("R8 recovers at next START", ack, 1);
    bus_stop();

    check("R9 sda_oe steady while SCL high", viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule